// File: doc/BRIEF.md
# Descriptor Ring Writeback Engine

This block returns finished descriptors to a host-memory ring. When asked to write back, it looks at how many used descriptors are waiting, where the hardware head index stands and how long the ring is. From these it works out how many entries one DMA write can carry. It then issues a single write request with a byte address and an entry count. When the write completes, it pops that many entries from the used queue and moves the head index forward, wrapping at the end of the ring.

Each request carries an alignment mask, given as a block size minus one. When no wrap is involved, the count is rounded down to a multiple of that block, so that partial blocks are held back. Only one write may be in flight at a time. A request that arrives during a write with a smaller (less restrictive) mask is remembered and is replayed once the current write finishes. A write that is cut short at the ring end is continued the same way. On each completion the engine also tells a companion fetch engine to start, if that engine reports itself idle.

Top module: `desc_wb_engine`

## Requirements
- R1: After reset the head index is 0, and `dma_req_o`, `pop_o`, `fetch_kick_o` and `busy_o` are all 0.
- R2: A request with mask 0, when used count plus head is below the ring length, raises `dma_req_o` in the cycle after the request. It carries `dma_cnt_o` equal to the used count and `dma_addr_o` equal to ring base plus head times the descriptor size (16 bytes by default).
- R3: With a nonzero mask and no wrap, the count is the used count with the mask bits cleared. For a mask of 2^k-1 this is the used count rounded down to a multiple of 2^k.
- R4: When used count plus head is at or above the ring length, the count is ring length minus head. After that write completes, a new writeback using the stored mask is evaluated in the cycle after completion, so its `dma_req_o` appears two cycles after the completion cycle.
- R5: A computed count of 0 issues no DMA write and leaves `busy_o` at 0.
- R6: While a write is outstanding, further requests issue nothing. A request with a smaller mask than the stored one causes a replay, with that mask, after completion. A request with an equal or larger mask causes no replay.
- R7: A completion (`dma_done_i` while busy) pulses `pop_o` with `pop_cnt_o` equal to the written count. In that same cycle `head_o` shows (head + count), minus the ring length if the sum reaches or exceeds it.
- R8: `dma_req_o` is a one-cycle pulse for each write.
- R9: `fetch_kick_o` pulses in the completion cycle if and only if `fetch_idle_i` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ring_base_i | input | AW | Byte address of ring entry 0 |
| ring_len_i | input | IW+1 | Ring length in entries |
| used_cnt_i | input | IW+1 | Used descriptors waiting to be written back |
| wb_req_i | input | 1 | Writeback request strobe |
| wb_mask_i | input | IW+1 | Alignment mask of the request |
| dma_req_o | output | 1 | DMA write request pulse |
| dma_addr_o | output | AW | Byte address of the write |
| dma_cnt_o | output | IW+1 | Entries in the write |
| dma_done_i | input | 1 | DMA write completed |
| head_o | output | IW | Hardware head index |
| pop_o | output | 1 | Pop strobe to the used queue |
| pop_cnt_o | output | IW+1 | Entries to pop |
| fetch_idle_i | input | 1 | Fetch engine is idle |
| fetch_kick_o | output | 1 | Start a descriptor fetch |
| busy_o | output | 1 | A write is outstanding |

## Verification
The assertions check several properties on every cycle: the request stays a single pulse, no request is issued while busy, a write never runs past the ring end, the head stays inside the ring and holds still after a completion, the engine is idle after each completion, and a fetch kick occurs only alongside a pop while the fetch engine is idle. The exact counts under masking, the wrap continuation, the replay or suppression of requests made mid-flight, and the resulting head sequence depend on the stimulus history. Only the bench scenarios, checked against its own ring model, can show those.

// File: rtl/desc_wb_pkg.sv
package desc_wb_pkg;
  typedef enum logic {
    WB_IDLE = 1'b0,
    WB_BUSY = 1'b1
  } wb_state_e;
endpackage

// File: rtl/desc_wb_count.sv
module desc_wb_count #(
  parameter int IW = 4,
  localparam int CW = IW + 1
) (
  input  logic [CW-1:0] used_i,
  input  logic [IW-1:0] head_i,
  input  logic [CW-1:0] len_i,
  input  logic [CW-1:0] mask_i,
  output logic [CW-1:0] cnt_o,
  output logic          wraps_o
);
  logic [CW:0]   total;
  logic [CW-1:0] head_ext;

  assign head_ext = {1'b0, head_i};
  assign total    = {1'b0, used_i} + {1'b0, head_ext};
  assign wraps_o  = total >= {1'b0, len_i};
  assign cnt_o    = wraps_o ? (len_i - head_ext) : (used_i & ~mask_i);
endmodule

// File: rtl/desc_wb_head.sv
module desc_wb_head #(
  parameter int IW = 4,
  localparam int CW = IW + 1
) (
  input  logic [IW-1:0] head_i,
  input  logic [CW-1:0] cnt_i,
  input  logic [CW-1:0] len_i,
  output logic [IW-1:0] head_nxt_o
);
  function automatic logic [IW-1:0] advance(input logic [IW-1:0] h,
                                            input logic [CW-1:0] c,
                                            input logic [CW-1:0] l);
    logic [CW:0] s;
    s = {2'b00, h} + {1'b0, c};
    if (s >= {1'b0, l}) s = s - {1'b0, l};
    return s[IW-1:0];
  endfunction

  assign head_nxt_o = advance(head_i, cnt_i, len_i);
endmodule

// File: rtl/desc_wb_addr.sv
module desc_wb_addr #(
  parameter int AW = 32,
  parameter int IW = 4,
  parameter int DESC_BYTES = 16
) (
  input  logic [AW-1:0] base_i,
  input  logic [IW-1:0] head_i,
  output logic [AW-1:0] addr_o
);
  localparam bit IS_POW2 = (DESC_BYTES & (DESC_BYTES - 1)) == 0;
  localparam int SHIFT   = $clog2(DESC_BYTES);

  generate
    if (IS_POW2) begin : g_shift
      assign addr_o = base_i + (AW'(head_i) << SHIFT);
    end else begin : g_mult
      assign addr_o = base_i + AW'(head_i) * AW'(DESC_BYTES);
    end
  endgenerate
endmodule

// File: rtl/desc_wb_engine.sv
module desc_wb_engine #(
  parameter int AW = 32,
  parameter int IW = 4,
  parameter int DESC_BYTES = 16,
  localparam int CW = IW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] ring_base_i,
  input  logic [CW-1:0] ring_len_i,
  input  logic [CW-1:0] used_cnt_i,
  input  logic          wb_req_i,
  input  logic [CW-1:0] wb_mask_i,
  output logic          dma_req_o,
  output logic [AW-1:0] dma_addr_o,
  output logic [CW-1:0] dma_cnt_o,
  input  logic          dma_done_i,
  output logic [IW-1:0] head_o,
  output logic          pop_o,
  output logic [CW-1:0] pop_cnt_o,
  input  logic          fetch_idle_i,
  output logic          fetch_kick_o,
  output logic          busy_o
);
  import desc_wb_pkg::*;

  wb_state_e     state_q;
  logic          more_q;
  logic          replay_q;
  logic          dma_req_q;
  logic [CW-1:0] mask_q;
  logic [CW-1:0] cnt_q;
  logic [IW-1:0] head_q;
  logic [AW-1:0] addr_q;

  // named internal events
  logic          busy;
  logic          done_fire;
  logic          start_eval;
  logic          issue;
  logic          narrower_req;
  logic          merged_more;
  logic [CW-1:0] eff_mask;
  logic [CW-1:0] calc_cnt;
  logic          calc_wraps;
  logic [IW-1:0] head_nxt;
  logic [AW-1:0] calc_addr;

  assign busy         = (state_q == WB_BUSY);
  assign done_fire    = dma_done_i && busy && !dma_req_q;
  assign narrower_req = wb_req_i && (wb_mask_i < mask_q);
  assign start_eval   = !busy && (wb_req_i || replay_q);
  assign eff_mask     = replay_q ? (narrower_req ? wb_mask_i : mask_q) : wb_mask_i;
  assign issue        = start_eval && (calc_cnt != '0);
  assign merged_more  = more_q || narrower_req;

  desc_wb_count #(.IW(IW)) u_count (
    .used_i  (used_cnt_i),
    .head_i  (head_q),
    .len_i   (ring_len_i),
    .mask_i  (eff_mask),
    .cnt_o   (calc_cnt),
    .wraps_o (calc_wraps)
  );

  desc_wb_head #(.IW(IW)) u_head (
    .head_i     (head_q),
    .cnt_i      (cnt_q),
    .len_i      (ring_len_i),
    .head_nxt_o (head_nxt)
  );

  desc_wb_addr #(.AW(AW), .IW(IW), .DESC_BYTES(DESC_BYTES)) u_addr (
    .base_i (ring_base_i),
    .head_i (head_q),
    .addr_o (calc_addr)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= WB_IDLE;
      more_q    <= 1'b0;
      replay_q  <= 1'b0;
      dma_req_q <= 1'b0;
      mask_q    <= '0;
      cnt_q     <= '0;
      head_q    <= '0;
      addr_q    <= '0;
    end else begin
      dma_req_q <= issue;
      replay_q  <= done_fire && merged_more;
      if (busy) begin
        if (narrower_req) mask_q <= wb_mask_i;
        if (done_fire) begin
          state_q <= WB_IDLE;
          head_q  <= head_nxt;
          more_q  <= 1'b0;
        end else if (narrower_req) begin
          more_q <= 1'b1;
        end
      end else if (issue) begin
        state_q <= WB_BUSY;
        cnt_q   <= calc_cnt;
        addr_q  <= calc_addr;
        more_q  <= calc_wraps;
        mask_q  <= eff_mask;
      end else if (start_eval) begin
        more_q <= 1'b0;
        mask_q <= eff_mask;
      end
    end
  end

  assign dma_req_o    = dma_req_q;
  assign dma_addr_o   = addr_q;
  assign dma_cnt_o    = cnt_q;
  assign head_o       = done_fire ? head_nxt : head_q;
  assign pop_o        = done_fire;
  assign pop_cnt_o    = done_fire ? cnt_q : '0;
  assign fetch_kick_o = done_fire && fetch_idle_i;
  assign busy_o       = busy;
endmodule

// File: rtl/desc_wb_checker.sv
module desc_wb_checker #(
  parameter int IW = 4,
  localparam int CW = IW + 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic [CW-1:0] ring_len_i,
  input logic          dma_req_o,
  input logic [CW-1:0] dma_cnt_o,
  input logic [IW-1:0] head_o,
  input logic          pop_o,
  input logic [CW-1:0] pop_cnt_o,
  input logic          fetch_idle_i,
  input logic          fetch_kick_o,
  input logic          busy_o,
  input logic          issue
);
  // R8: request lasts one cycle
  p_req_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req_o |=> !dma_req_o);

  // R6: nothing is issued while a write is outstanding
  p_no_issue_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req_o |-> !$past(busy_o));

  // R6: an issue decision makes the engine busy next cycle
  p_issue_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    issue |=> (busy_o && dma_req_o));

  // R4: a write never runs past the ring end
  p_no_overrun_r4: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req_o |-> (({1'b0, dma_cnt_o} + {2'b00, head_o}) <= {1'b0, ring_len_i}));

  // R7: head stays inside the ring
  p_head_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ring_len_i != '0) |-> ({1'b0, head_o} < ring_len_i));

  // R7: a pop carries a nonzero count and leaves the engine idle
  p_pop_cnt_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pop_o |-> (pop_cnt_o != '0));
  p_pop_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pop_o |=> (!busy_o && $stable(head_o)));

  // R9: fetch kick only with a pop while the fetch engine is idle
  p_kick_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_kick_o |-> (pop_o && fetch_idle_i));
endmodule

bind desc_wb_engine desc_wb_checker #(.IW(IW)) u_chk (.*);

// File: tb/desc_wb_engine_tb.sv
`timescale 1ns/1ps
module desc_wb_engine_tb_top;
  localparam int AW = 32;
  localparam int IW = 4;
  localparam int CW = IW + 1;
  localparam int LEN = 16;
  localparam int DB = 16;
  localparam logic [AW-1:0] BASE = 32'h0000_1000;
  localparam int NV = 8;
  // {used[4:0], mask[4:0]}
  localparam logic [9:0] VEC [NV] = '{
    {5'd3, 5'd0}, {5'd5, 5'd1}, {5'd7, 5'd3}, {5'd9, 5'd7},
    {5'd12, 5'd0}, {5'd6, 5'd1}, {5'd1, 5'd0}, {5'd14, 5'd3}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] ring_base_i = BASE;
  logic [CW-1:0] ring_len_i = CW'(LEN);
  logic [CW-1:0] used_cnt_i = '0;
  logic          wb_req_i = 1'b0;
  logic [CW-1:0] wb_mask_i = '0;
  logic          dma_done_i = 1'b0;
  logic          fetch_idle_i = 1'b1;
  logic          dma_req_o, pop_o, fetch_kick_o, busy_o;
  logic [AW-1:0] dma_addr_o;
  logic [CW-1:0] dma_cnt_o, pop_cnt_o;
  logic [IW-1:0] head_o;

  int n_cmp = 0;
  int n_bad = 0;
  int head_m = 0;

  always #2 clk = ~clk;

  desc_wb_engine #(.AW(AW), .IW(IW), .DESC_BYTES(DB)) dut_i (
    .clk, .rst_n, .ring_base_i, .ring_len_i, .used_cnt_i, .wb_req_i,
    .wb_mask_i, .dma_req_o, .dma_addr_o, .dma_cnt_o, .dma_done_i, .head_o,
    .pop_o, .pop_cnt_o, .fetch_idle_i, .fetch_kick_o, .busy_o
  );

  task automatic chk(input string req, input string what,
                     input longint act, input longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int exp_cnt(input int used, input int mask,
                                 input int head, output bit wrap);
    wrap = (used + head) >= LEN;
    if (wrap) return LEN - head;
    return used - (used % (mask + 1));
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    head_m = 0;
    chk("R1", "head", head_o, 0);
    chk("R1", "dma_req", dma_req_o, 0);
    chk("R1", "pop", pop_o, 0);
    chk("R1", "kick", fetch_kick_o, 0);
    chk("R1", "busy", busy_o, 0);
  endtask

  // completes an outstanding write of c entries, in the cycle dma_done is driven
  task automatic complete(input string req, input int c, input int used_left);
    chk(req, "req pulse", dma_req_o, 0);
    dma_done_i = 1'b1;
    #1;
    chk("R7", "pop", pop_o, 1);
    chk("R7", "pop_cnt", pop_cnt_o, c);
    chk("R7", "head", head_o, (head_m + c) % LEN);
    chk("R9", "kick", fetch_kick_o, fetch_idle_i);
    @(negedge clk);
    dma_done_i = 1'b0;
    head_m = (head_m + c) % LEN;
    used_cnt_i = CW'(used_left);
  endtask

  task automatic check_issue(input string req, input int c);
    chk(req, "dma_req", dma_req_o, 1);
    chk(req, "dma_cnt", dma_cnt_o, c);
    chk(req, "dma_addr", dma_addr_o, BASE + head_m * DB);
    @(negedge clk);
    chk("R8", "dma_req second cycle", dma_req_o, 0);
  endtask

  task automatic run_wb(input int used, input int mask);
    int c;
    int used_m;
    bit wrap;
    string tag;
    used_m = used;
    used_cnt_i = CW'(used);
    wb_mask_i = CW'(mask);
    wb_req_i = 1'b1;
    @(negedge clk);
    wb_req_i = 1'b0;
    c = exp_cnt(used_m, mask, head_m, wrap);
    tag = wrap ? "R4" : ((mask != 0) ? "R3" : "R2");
    forever begin
      if (c == 0) begin
        chk("R5", "no dma", dma_req_o, 0);
        chk("R5", "busy", busy_o, 0);
        break;
      end
      check_issue(tag, c);
      used_m = used_m - c;
      complete(tag, c, used_m);
      @(negedge clk);
      if (!wrap) begin
        chk(tag, "no replay", dma_req_o, 0);
        break;
      end
      c = exp_cnt(used_m, mask, head_m, wrap);
      tag = "R4";
    end
  endtask

  initial begin
    #800000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    do_reset();

    for (int i = 0; i < NV; i++) begin
      run_wb(int'(VEC[i][9:5]), int'(VEC[i][4:0]));
    end

    // directed: narrower request mid-flight is replayed
    do_reset();
    used_cnt_i = 5'd6; wb_mask_i = 5'd3; wb_req_i = 1'b1;
    @(negedge clk);
    chk("R3", "dma_cnt", dma_cnt_o, 4);
    chk("R3", "dma_req", dma_req_o, 1);
    wb_mask_i = 5'd0;          // still high: busy-time request
    @(negedge clk);
    wb_req_i = 1'b0;
    chk("R6", "no second issue", dma_req_o, 0);
    complete("R6", 4, 2);
    @(negedge clk);
    chk("R6", "replay dma_req", dma_req_o, 1);
    chk("R6", "replay cnt", dma_cnt_o, 2);
    chk("R6", "replay addr", dma_addr_o, BASE + 4 * DB);
    @(negedge clk);
    complete("R6", 2, 0);
    chk("R7", "head after replay", head_o, 6);

    // directed: wider request mid-flight is dropped; fetch engine busy
    used_cnt_i = 5'd5; wb_mask_i = 5'd0; wb_req_i = 1'b1;
    @(negedge clk);
    chk("R2", "dma_cnt", dma_cnt_o, 5);
    wb_mask_i = 5'd3;
    @(negedge clk);
    wb_req_i = 1'b0;
    fetch_idle_i = 1'b0;
    complete("R6", 5, 0);
    fetch_idle_i = 1'b1;
    used_cnt_i = 5'd3;
    @(negedge clk);
    chk("R6", "wider not replayed", dma_req_o, 0);
    @(negedge clk);
    chk("R6", "wider not replayed busy", busy_o, 0);

    // directed: mask swallows whole count
    used_cnt_i = 5'd3; wb_mask_i = 5'd3; wb_req_i = 1'b1;
    @(negedge clk);
    wb_req_i = 1'b0;
    chk("R5", "masked to zero", dma_req_o, 0);
    @(negedge clk);
    chk("R5", "still idle", busy_o, 0);
    chk("R5", "head kept", head_o, 11);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule